// File: doc/BRIEF.md
# DRAM Data Pin Drive and Write Strobe Gating

This block is a clocked model of the device-side logic that decides when a dynamic RAM's data pins are driven and when data on them is taken in. It samples the four active-low control pins (row strobe, column strobe, write enable, output enable) on a fast system clock. It finds their edges by comparing each sample with the one before. From the levels and the order of the edges it tracks three things: whether a memory cycle is open, whether the internal data path is open, and whether the current column access began as an early write.

It drives an output enable for an external tristate buffer and a data word from an abstract storage read port. It also sends a one-clock write strobe with the captured input word toward that storage. When the row strobe closes a cycle while the output is being driven, the data word is frozen. The pins keep showing that word until the column strobe rises. The block is meant for checking a memory controller against device-like pin behaviour. Array storage, address decoding and analog timing are left to the surroundings.

Top module: `dio_gate`

## Requirements
- R1: While reset is asserted, `dq_oe` and `wr_stb` are 0 and `dq_out` is all zeros.
- R2: After a falling `ras_n`, a falling `cas_n` with `we_n` high and `oe_n` low sets `dq_oe` to 1 with `dq_out` equal to `rd_data`. Every pin change reaches the outputs on the second rising clock edge after it is applied. While the output is driven, `dq_out` follows `rd_data` one edge later.
- R3: A rising `cas_n` clears `dq_oe` on the second rising edge. A later fall of `cas_n` inside the same row cycle drives the pins again.
- R4: With no open row cycle, a falling `cas_n` or `we_n` leaves `dq_oe` at 0 and creates no `wr_stb`.
- R5: `oe_n` high holds `dq_oe` at 0 even when the output would otherwise be driven. Returning `oe_n` low drives the pins again.
- R6: If `ras_n` rises while `dq_oe` is 1 and `cas_n` is low, `dq_oe` stays 1 and `dq_out` keeps its last word whatever `rd_data` does. `oe_n` can still turn the output off and on. The rise of `cas_n` ends this state. If the output was off when `ras_n` rose, nothing is held.
- R7: If `we_n` is low when the data path opens, the pins stay undriven until `cas_n` rises or the cycle ends, even if `we_n` returns high meanwhile.
- R8: Inside an open row cycle, `wr_stb` is 1 for exactly one clock on the later of the `we_n` and `cas_n` falls. `wr_data` then equals the `dq_in` value present at that fall.
- R9: `we_n` low inside an open row cycle holds `dq_oe` at 0. If `we_n` rises after a late write, reads resume without a new `cas_n` fall.
- R10: If `ras_n` is already low when reset is released, no row cycle opens until `ras_n` has risen and fallen again.
- R11: If `cas_n` is already low when `ras_n` falls, the data path opens on the `ras_n` fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ras_n | input | 1 | Row strobe pin, active low |
| cas_n | input | 1 | Column strobe pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| dq_in | input | DW | Word seen on the data pins |
| rd_data | input | DW | Word from the storage read port |
| dq_out | output | DW | Word to the tristate data driver |
| dq_oe | output | 1 | Tristate driver enable |
| wr_stb | output | 1 | One-clock write strobe to storage |
| wr_data | output | DW | Word captured for the write |

## Verification
The hardest case to reach from the pins is the frozen-output state. The row strobe must rise while the column strobe is still low and the pins are being driven. The stimulus first opens a normal read, then raises `ras_n` alone and changes `rd_data` afterwards, so that a held word can be told apart from a live one. The early-write case is reached in a similar way: `we_n` falls before `cas_n` and then returns high while `cas_n` is still low. A plain write-enable check cannot produce the undriven result that this case requires.

// File: rtl/dio_pkg.sv
package dio_pkg;

  // Raw pin levels of the four active-low controls (1 = high = inactive).
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic oe;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{ras: 1'b1, cas: 1'b1, we: 1'b1, oe: 1'b1};

  // Edge flags derived from two consecutive samples.
  typedef struct packed {
    logic ras_fall;
    logic ras_rise;
    logic cas_fall;
    logic we_fall;
  } edge_t;

endpackage

// File: rtl/dio_sample.sv
module dio_sample
  import dio_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_q,
  input  ctl_t          pin_ctl,
  input  logic [DW-1:0] pin_dq,
  output ctl_t          cur,
  output edge_t         edg,
  output logic [DW-1:0] cur_dq
);

  localparam int VLD_W = 2;

  ctl_t             smp_q, smp_d;
  ctl_t             prv_q, prv_d;
  logic [DW-1:0]    dq_q, dq_d;
  logic [VLD_W-1:0] vld_q, vld_d;
  logic             cmp_ok;

  // next state
  always_comb begin
    smp_d = pin_ctl;
    prv_d = smp_q;
    dq_d  = pin_dq;
    vld_d = {vld_q[VLD_W-2:0], 1'b1};
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      smp_q <= CTL_IDLE;
      prv_q <= CTL_IDLE;
      dq_q  <= '0;
      vld_q <= '0;
    end else begin
      smp_q <= smp_d;
      prv_q <= prv_d;
      dq_q  <= dq_d;
      vld_q <= vld_d;
    end
  end

  // Edges only count once both sample registers hold real pin values.
  assign cmp_ok = vld_q[VLD_W-1];

  always_comb begin
    edg.ras_fall = cmp_ok &  prv_q.ras & ~smp_q.ras;
    edg.ras_rise = cmp_ok & ~prv_q.ras &  smp_q.ras;
    edg.cas_fall = cmp_ok &  prv_q.cas & ~smp_q.cas;
    edg.we_fall  = cmp_ok &  prv_q.we  & ~smp_q.we;
  end

  assign cur    = smp_q;
  assign cur_dq = dq_q;

endmodule

// File: rtl/dio_track.sv
module dio_track
  import dio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_q,
  input  ctl_t  cur,
  input  edge_t edg,
  output logic  drive_nx,
  output logic  load_nx,
  output logic  strobe_nx
);

  logic cyc_q, cyc_d;
  logic path_q, path_d;
  logic early_q, early_d;
  logic live_q, live_d;
  logic hold_q, hold_d;

  // next state
  always_comb begin
    // Row cycle opens only on a seen fall, closes on a high level.
    if (edg.ras_fall)
      cyc_d = 1'b1;
    else if (cur.ras)
      cyc_d = 1'b0;
    else
      cyc_d = cyc_q;

    // Column path open while the cycle is open and the column strobe is low.
    path_d = cyc_d & ~cur.cas;

    // Write enable already low at the moment the path opens: early write.
    early_d = path_d & (early_q | (~path_q & ~cur.we));

    live_d = path_d & cur.we & ~cur.oe & ~early_d;

    // Row strobe rising under a driven output freezes the word.
    hold_d = ~cur.cas & ~cyc_d & (hold_q | (edg.ras_rise & live_q));
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cyc_q   <= 1'b0;
      path_q  <= 1'b0;
      early_q <= 1'b0;
      live_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      cyc_q   <= cyc_d;
      path_q  <= path_d;
      early_q <= early_d;
      live_q  <= live_d;
      hold_q  <= hold_d;
    end
  end

  assign drive_nx  = live_d | (hold_d & ~cur.oe);
  assign load_nx   = live_d;
  assign strobe_nx = cyc_d & ((edg.cas_fall & ~cur.we) | (edg.we_fall & ~cur.cas));

endmodule

// File: rtl/dio_out_stage.sv
module dio_out_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_q,
  input  logic          drive_nx,
  input  logic          load_nx,
  input  logic          strobe_nx,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] cur_dq,
  output logic          dq_oe,
  output logic [DW-1:0] dq_out,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data
);

  logic          oe_q;
  logic          stb_q;
  logic [DW-1:0] out_q;
  logic [DW-1:0] wd_q;

  // control flags
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      oe_q  <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      oe_q  <= drive_nx;
      stb_q <= strobe_nx;
    end
  end

  // read word: loads only while live, so it freezes otherwise
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)
      out_q <= '0;
    else if (load_nx)
      out_q <= rd_data;
  end

  // write word: captured with the strobe
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)
      wd_q <= '0;
    else if (strobe_nx)
      wd_q <= cur_dq;
  end

  assign dq_oe   = oe_q;
  assign wr_stb  = stb_q;
  assign dq_out  = out_q;
  assign wr_data = wd_q;

endmodule

// File: rtl/dio_gate.sv
module dio_gate
  import dio_pkg::*;
#(
  parameter int DW         = 16,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] dq_in,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          wr_stb,
  output logic [DW-1:0] wr_data
);

  logic [RST_STAGES-1:0] rst_sync;
  logic                  rst_q;

  // Reset synchronizer: asserts at once, releases on the clock.
  genvar g;
  generate
    for (g = 0; g < RST_STAGES; g++) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          rst_sync[g] <= 1'b0;
        else if (g == 0)
          rst_sync[g] <= 1'b1;
        else
          rst_sync[g] <= rst_sync[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_q = rst_sync[RST_STAGES-1];

  ctl_t          pin_ctl;
  ctl_t          cur;
  edge_t         edg;
  logic [DW-1:0] cur_dq;
  logic          drive_nx, load_nx, strobe_nx;
  logic          s_ras, s_cas, s_we, s_oe;

  assign pin_ctl = '{ras: ras_n, cas: cas_n, we: we_n, oe: oe_n};

  dio_sample #(.DW(DW)) u_sample (
    .clk     (clk),
    .rst_q   (rst_q),
    .pin_ctl (pin_ctl),
    .pin_dq  (dq_in),
    .cur     (cur),
    .edg     (edg),
    .cur_dq  (cur_dq)
  );

  dio_track u_track (
    .clk       (clk),
    .rst_q     (rst_q),
    .cur       (cur),
    .edg       (edg),
    .drive_nx  (drive_nx),
    .load_nx   (load_nx),
    .strobe_nx (strobe_nx)
  );

  dio_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_q     (rst_q),
    .drive_nx  (drive_nx),
    .load_nx   (load_nx),
    .strobe_nx (strobe_nx),
    .rd_data   (rd_data),
    .cur_dq    (cur_dq),
    .dq_oe     (dq_oe),
    .dq_out    (dq_out),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data)
  );

  // Sampled levels brought out for the bound checker.
  assign s_ras = cur.ras;
  assign s_cas = cur.cas;
  assign s_we  = cur.we;
  assign s_oe  = cur.oe;

endmodule

// File: rtl/dio_gate_chk.sv
module dio_gate_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_q,
  input logic          s_ras,
  input logic          s_cas,
  input logic          s_we,
  input logic          s_oe,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out,
  input logic          wr_stb
);

  // R3: a sampled high column strobe leaves the driver off next edge
  assert_cas_high_off_R3: assert property (@(posedge clk) disable iff (!rst_q)
    s_cas |=> !dq_oe);

  // R5: output enable pin high blocks the driver
  assert_oe_blocks_R5: assert property (@(posedge clk) disable iff (!rst_q)
    s_oe |=> !dq_oe);

  // R9: write enable low inside a row cycle blocks the driver
  assert_we_low_off_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (!s_we && !s_ras) |=> !dq_oe);

  // R8: the write strobe never lasts two clocks
  assert_stb_single_R8: assert property (@(posedge clk) disable iff (!rst_q)
    wr_stb |=> !wr_stb);

  // R6: row strobe rising under a driven output keeps the word
  assert_hold_word_R6: assert property (@(posedge clk) disable iff (!rst_q)
    ($rose(s_ras) && dq_oe && !s_cas && !s_oe) |=> (dq_oe && $stable(dq_out)));

  // R1: quiet outputs while reset holds
  always @(posedge clk) begin
    if (!rst_q) begin
      assert_reset_quiet_R1: assert (!dq_oe && !wr_stb);
    end
  end

endmodule

bind dio_gate dio_gate_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_q  (rst_q),
  .s_ras  (s_ras),
  .s_cas  (s_cas),
  .s_we   (s_we),
  .s_oe   (s_oe),
  .dq_oe  (dq_oe),
  .dq_out (dq_out),
  .wr_stb (wr_stb)
);

// File: tb/dio_gate_test.sv
module dio_gate_test;

  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          ras_n, cas_n, we_n, oe_n;
  logic [DW-1:0] dq_in, rd_data;
  logic [DW-1:0] dq_out, wr_data;
  logic          dq_oe, wr_stb;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  dio_gate #(.DW(DW)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .dq_in   (dq_in),
    .rd_data (rd_data),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .wr_stb  (wr_stb),
    .wr_data (wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ras_n = 1; cas_n = 1; we_n = 1; oe_n = 1;
    tick(4);
  endtask

  // R1 and R10: reset values, row strobe low across reset release
  task automatic t_reset_ras_low();
    rst_n = 0; ras_n = 0; cas_n = 0; we_n = 1; oe_n = 0;
    dq_in = '0; rd_data = 16'h1357;
    tick(3);
    check("R1", "dq_oe in reset", dq_oe, 0);
    check("R1", "wr_stb in reset", wr_stb, 0);
    check("R1", "dq_out in reset", dq_out, 0);
    rst_n = 1;
    tick(8);
    check("R10", "no cycle from stale ras low", dq_oe, 0);
    ras_n = 1; tick(2);
    ras_n = 0; tick(2);
    check("R10", "cycle after fresh ras fall", dq_oe, 1);
    check("R10", "word after fresh ras fall", dq_out, 16'h1357);
    idle();
  endtask

  // R2 and R3: read, flow-through, page-mode repeat
  task automatic t_read_page();
    oe_n = 0; we_n = 1;
    ras_n = 0; tick();
    rd_data = 16'hA0A1;
    cas_n = 0; tick();
    check("R2", "dq_oe one edge after cas", dq_oe, 0);
    tick();
    check("R2", "dq_oe two edges after cas", dq_oe, 1);
    check("R2", "read word", dq_out, 16'hA0A1);
    rd_data = 16'hB0B1; tick();
    check("R2", "word follows rd_data", dq_out, 16'hB0B1);
    cas_n = 1; tick();
    check("R3", "still driven one edge after cas rise", dq_oe, 1);
    tick();
    check("R3", "off after cas rise", dq_oe, 0);
    cas_n = 0; tick(2);
    check("R3", "driven again on page access", dq_oe, 1);
    idle();
  endtask

  // R5: output enable gating
  task automatic t_oe_gate();
    oe_n = 0; we_n = 1; rd_data = 16'h0C0C;
    ras_n = 0; tick(); cas_n = 0; tick(2);
    check("R5", "driven with oe low", dq_oe, 1);
    oe_n = 1; tick(2);
    check("R5", "off with oe high", dq_oe, 0);
    oe_n = 0; tick(2);
    check("R5", "driven after oe low again", dq_oe, 1);
    idle();
  endtask

  // R4 and R11: column strobe with no open row cycle
  task automatic t_cas_only();
    we_n = 1; oe_n = 0; rd_data = 16'h4411;
    cas_n = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R4", "no drive without row cycle", dq_oe, 0);
    end
    we_n = 0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R4", "no strobe without row cycle", wr_stb, 0);
    end
    we_n = 1; tick(2);
    ras_n = 0; tick();
    check("R11", "not yet driven", dq_oe, 0);
    tick();
    check("R11", "driven on ras fall with cas low", dq_oe, 1);
    check("R11", "word", dq_out, 16'h4411);
    idle();
  endtask

  // R6: frozen word after row strobe rise
  task automatic t_hold();
    oe_n = 0; we_n = 1; rd_data = 16'hC0DE;
    ras_n = 0; tick(); cas_n = 0; tick(2);
    check("R6", "driven before ras rise", dq_oe, 1);
    ras_n = 1; tick(2);
    check("R6", "still driven after ras rise", dq_oe, 1);
    check("R6", "held word", dq_out, 16'hC0DE);
    rd_data = 16'hDEAD; tick(2);
    check("R6", "word frozen", dq_out, 16'hC0DE);
    oe_n = 1; tick(2);
    check("R6", "oe high turns hold off", dq_oe, 0);
    oe_n = 0; tick(2);
    check("R6", "oe low restores hold", dq_oe, 1);
    check("R6", "held word kept", dq_out, 16'hC0DE);
    cas_n = 1; tick(2);
    check("R6", "cas rise ends hold", dq_oe, 0);
    idle();
    // output off at ras rise: nothing held
    oe_n = 1; we_n = 1; rd_data = 16'h7777;
    ras_n = 0; tick(); cas_n = 0; tick(2);
    ras_n = 1; tick(2);
    oe_n = 0; tick(2);
    check("R6", "no hold when output was off", dq_oe, 0);
    idle();
  endtask

  // R7 and R8: early write
  task automatic t_early();
    oe_n = 0; we_n = 1;
    ras_n = 0; tick();
    we_n = 0; tick();
    check("R8", "no strobe on we fall before cas", wr_stb, 0);
    dq_in = 16'hE1E2;
    cas_n = 0; tick();
    check("R8", "strobe not yet", wr_stb, 0);
    tick();
    check("R8", "strobe at cas fall", wr_stb, 1);
    check("R8", "captured word", wr_data, 16'hE1E2);
    check("R7", "pins undriven in early write", dq_oe, 0);
    dq_in = 16'h0000; tick();
    check("R8", "strobe one clock only", wr_stb, 0);
    check("R8", "word held after strobe", wr_data, 16'hE1E2);
    we_n = 1; tick(2);
    check("R7", "still undriven after we rise", dq_oe, 0);
    tick(2);
    check("R7", "still undriven later", dq_oe, 0);
    cas_n = 1; tick(2);
    cas_n = 0; tick(2);
    check("R7", "read after new cas fall", dq_oe, 1);
    check("R8", "no strobe on read access", wr_stb, 0);
    idle();
  endtask

  // R8 and R9: late write after read
  task automatic t_late();
    oe_n = 0; we_n = 1; rd_data = 16'h5A5A;
    ras_n = 0; tick(); cas_n = 0; tick(2);
    check("R9", "read before late write", dq_oe, 1);
    dq_in = 16'hF00D;
    we_n = 0; tick();
    check("R8", "late strobe not yet", wr_stb, 0);
    tick();
    check("R8", "strobe at we fall", wr_stb, 1);
    check("R8", "late captured word", wr_data, 16'hF00D);
    check("R9", "we low turns driver off", dq_oe, 0);
    tick();
    check("R8", "late strobe one clock", wr_stb, 0);
    we_n = 1; tick(2);
    check("R9", "read resumes after we rise", dq_oe, 1);
    idle();
  endtask

  initial begin
    t_reset_ras_low();
    t_read_page();
    t_oe_gate();
    t_cas_only();
    t_hold();
    t_early();
    t_late();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule